// File: doc/BRIEF.md
# Expansion Bus Contention Detector

Several repeater devices share one expansion bus. Each device pulls its own active-low request line when it wants to drive the shared data and status lines. This block watches every request line and drives two global active-low lines back to all devices. The acknowledge line goes low when exactly one device is requesting, so that device may drive the bus. The collision line goes low when two or more devices request at once, so every device learns of the contention.

The number of request lines is a parameter of at least 2. The exactly-one and more-than-one tests come from a prefix chain that grows with that count, so no case is written out by hand. By default the outputs follow the requests combinationally. A parameter adds one register stage on the common bus clock. In that variant, reset forces both outputs to their deasserted (high) level.

Top module: `busarb_top`

## Requirements
- R1: `ackN` is 0 (asserted) exactly when one bit of `reqN` is 0 and all the other bits are 1; otherwise it is 1.
- R2: `colN` is 0 (asserted) exactly when two or more bits of `reqN` are 0; otherwise it is 1.
- R3: When every bit of `reqN` is 1 (no device requesting), both `ackN` and `colN` are 1.
- R4: `ackN` and `colN` are never both 0 at the same time.
- R5: With `REG_OUT` = 1, `ackN` and `colN` after a rising edge of `clk` show the R1/R2 result for the `reqN` value sampled at that edge, and they hold that value until the next edge.
- R6: With `REG_OUT` = 1, while `rstN` is 0 both `ackN` and `colN` are 1, whatever `reqN` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common bus clock; used only when REG_OUT = 1 |
| rstN | input | 1 | Asynchronous active-low reset of the output stage |
| reqN | input | NUM_REQ | Active-low request, one bit per device |
| ackN | output | 1 | Active-low: exactly one device requests |
| colN | output | 1 | Active-low: more than one device requests |

## Verification
The block holds no state except the optional output register. A fault in the prefix chain therefore shows up directly in the outputs for the request patterns it affects. In combinational mode the faulty output appears in the same cycle; in registered mode it appears one clock later. The bench checks every request pattern of a four-device build, so a fault that affects only some bit positions is still caught. It also checks a three-device build with the register stage, to cover the one-edge latency and the reset level.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  // Summary of the request vector, in asserted-true form.
  typedef struct packed {
    logic anyReq;
    logic manyReq;
  } reqSummary_t;

  // Strobes from the control decode to the output stage.
  typedef struct packed {
    logic ackOn;
    logic colOn;
  } outStrobes_t;

endpackage

// File: rtl/busarb_reduce.sv
module busarb_reduce #(
  parameter int NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0]   reqN,
  output busarb_pkg::reqSummary_t summary
);
  localparam int CHAIN_LEN = NUM_REQ + 1;

  logic [NUM_REQ-1:0]   reqOn;
  logic [CHAIN_LEN-1:0] seenOne;
  logic [CHAIN_LEN-1:0] seenTwo;

  assign reqOn      = ~reqN;
  assign seenOne[0] = 1'b0;
  assign seenTwo[0] = 1'b0;

  // Prefix chain: stage i+1 knows whether one or two requests appeared among bits 0..i.
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chain
    assign seenOne[i+1] = seenOne[i] | reqOn[i];
    assign seenTwo[i+1] = seenTwo[i] | (seenOne[i] & reqOn[i]);
  end

  assign summary.anyReq  = seenOne[NUM_REQ];
  assign summary.manyReq = seenTwo[NUM_REQ];
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl (
  input  busarb_pkg::reqSummary_t summary,
  output busarb_pkg::outStrobes_t strobes
);
  always_comb begin
    strobes.ackOn = summary.anyReq & ~summary.manyReq;
    strobes.colOn = summary.manyReq;
  end
endmodule

// File: rtl/busarb_outstage.sv
module busarb_outstage #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busarb_pkg::outStrobes_t strobes,
  output logic                    ackN,
  output logic                    colN
);
  if (REG_OUT) begin : g_reg
    logic ackQ, colQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ackQ <= 1'b1;
        colQ <= 1'b1;
      end else begin
        ackQ <= ~strobes.ackOn;
        colQ <= ~strobes.colOn;
      end
    end
    assign ackN = ackQ;
    assign colN = colQ;
  end else begin : g_comb
    logic unusedClkRst;
    assign unusedClkRst = clk & rstN;
    assign ackN = ~strobes.ackOn;
    assign colN = ~strobes.colOn;
  end
endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
  parameter int NUM_REQ = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqN,
  output logic               ackN,
  output logic               colN
);
  busarb_pkg::reqSummary_t summary;
  busarb_pkg::outStrobes_t strobes;

  busarb_reduce #(.NUM_REQ(NUM_REQ)) u_reduce (
    .reqN(reqN), .summary(summary)
  );

  busarb_ctrl u_ctrl (
    .summary(summary), .strobes(strobes)
  );

  busarb_outstage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ackN(ackN), .colN(colN)
  );
endmodule

// File: rtl/busarb_checker.sv
module busarb_checker #(
  parameter int NUM_REQ = 4,
  parameter bit REG_OUT = 1'b0
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqN,
  input logic               ackN,
  input logic               colN
);
  // R4
  a_r4_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(!ackN && !colN));

  if (REG_OUT) begin : g_reg
    // R1 and R5
    a_r1_ack_one_late: assert property (@(posedge clk) disable iff (!rstN)
      ($countones(~reqN) == 1) |=> !ackN);
    // R2 and R5
    a_r2_col_many_late: assert property (@(posedge clk) disable iff (!rstN)
      ($countones(~reqN) >= 2) |=> !colN);
    // R3
    a_r3_idle_late: assert property (@(posedge clk) disable iff (!rstN)
      (reqN == '1) |=> (ackN && colN));
    // R6
    a_r6_reset_level: assert property (@(posedge clk)
      !rstN |=> (ackN && colN));
  end else begin : g_comb
    // R1
    a_r1_ack_one: assert property (@(posedge clk) disable iff (!rstN)
      !ackN == ($countones(~reqN) == 1));
    // R2
    a_r2_col_many: assert property (@(posedge clk) disable iff (!rstN)
      !colN == ($countones(~reqN) >= 2));
    // R3
    a_r3_idle: assert property (@(posedge clk) disable iff (!rstN)
      (reqN == '1) |-> (ackN && colN));
  end
endmodule

bind busarb_top busarb_checker #(.NUM_REQ(NUM_REQ), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_busarb_top.sv
module tb_busarb_top;
  localparam int N_COMB = 4;
  localparam int N_REG  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N_COMB-1:0] reqN = '1;
  logic ackN, colN;
  logic [N_REG-1:0] reqRegN = '1;
  logic ackRegN, colRegN;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  busarb_top #(.NUM_REQ(N_COMB), .REG_OUT(1'b0)) dut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .ackN(ackN), .colN(colN)
  );

  busarb_top #(.NUM_REQ(N_REG), .REG_OUT(1'b1)) dutReg (
    .clk(clk), .rstN(rstN), .reqN(reqRegN), .ackN(ackRegN), .colN(colRegN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic int lowCount(input logic [7:0] v, input int w);
    int n = 0;
    for (int b = 0; b < w; b++) if (!v[b]) n++;
    return n;
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    // R6: registered outputs deasserted while reset is held, even with requests present
    reqRegN = '0;
    repeat (3) @(negedge clk);
    check("R6 ackN in reset", ackRegN, 1'b1);
    check("R6 colN in reset", colRegN, 1'b1);
    reqRegN = '1;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: every pattern of the four-device combinational build
    for (int p = 0; p < (1 << N_COMB); p++) begin
      int k;
      reqN = p[N_COMB-1:0];
      #1;
      k = lowCount({4'hF, reqN}, N_COMB);
      check("R1 ackN", ackN, !(k == 1));
      check("R2 colN", colN, !(k >= 2));
      check("R4 not both", !ackN && !colN, 1'b0);
      if (k == 0) begin
        check("R3 idle ackN", ackN, 1'b1);
        check("R3 idle colN", colN, 1'b1);
      end
      @(negedge clk);
    end

    // R5: registered build, one-edge latency, value held until next edge
    for (int p = 0; p < (1 << N_REG); p++) begin
      int k;
      logic prevAck, prevCol;
      prevAck = ackRegN;
      prevCol = colRegN;
      reqRegN = p[N_REG-1:0];
      #1;
      check("R5 ackN held before edge", ackRegN, prevAck);
      check("R5 colN held before edge", colRegN, prevCol);
      k = lowCount({5'h1F, reqRegN}, N_REG);
      @(posedge clk);
      #1;
      check("R5 R1 ackN after edge", ackRegN, !(k == 1));
      check("R5 R2 colN after edge", colRegN, !(k >= 2));
      check("R4 registered not both", !ackRegN && !colRegN, 1'b0);
      @(negedge clk);
    end

    // R6: asserting reset again forces the registered outputs high
    reqRegN = 3'b000;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R6 ackN on reset entry", ackRegN, 1'b1);
    check("R6 colN on reset entry", colRegN, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule